// File: doc/BRIEF.md
# DMA Command Ring Pointer Controller

This block keeps the software-visible state of one circular command ring that a DMA engine drains. Software sets up the ring through a small register port: a 256-byte aligned base address, a ring size given as log2 of the dword count, the producer and consumer pointers, and a memory address to which the consumer pointer can be mirrored. Once the enable bit is set, the block tells the downstream fetch unit whether commands are waiting and at which address the next one starts.

Each time the fetch unit reports a finished command, the consumer pointer advances by the command's dword length and wraps at the ring size. When mirroring is on, the new pointer value is also sent out as a single memory-write request. Only one such request is in flight at a time. Advances made while a request waits are merged into one follow-up request carrying the latest pointer.

Top module: `ringptr_top`

## Requirements
- R1: After reset every register reads 0, `ringEmpty` is 1, and both `fetchReady` and `wbValid` are 0.
- R2: The read pointer (address 3) and the write pointer (address 4) are byte offsets. A write keeps only bits 17:2 (mask 0x3fffc), and a read returns the masked value.
- R3: The control register (address 0) holds the enable in bit 0, the log2 dword ring size in bits 5:1 and the writeback enable in bit 6. It reads back those 7 bits, and all higher bits read 0.
- R4: Address 1 holds the base address bits 39:8 and address 2 holds the bits above 39. `fetchAddr` equals the base address plus the read pointer's byte offset.
- R5: `ringEmpty` is 1 exactly when the read and write pointers are equal. `fetchReady` is 1 only when the ring is enabled and not empty.
- R6: A `consumeValid` pulse with the ring enabled and not empty advances the read pointer by `consumeDwords` dwords, modulo 2^size. When the ring is disabled or empty the pulse leaves the read pointer and `fetchAddr` unchanged.
- R7: A write-pointer write while the ring is disabled updates the register but keeps `fetchReady` low. Setting the enable later raises `fetchReady`.
- R8: With writeback enabled, each accepted advance issues a request on `wbValid`. The request carries `wbAddr` = {address 6, address 5 with bits 1:0 forced to 0} and `wbData` = the new read-pointer byte offset. With writeback disabled, no request is issued.
- R9: At most one writeback request is outstanding. While `wbReady` is low, `wbValid` and `wbData` hold. Advances made during that wait produce exactly one follow-up request, carrying the latest pointer, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, acts as the soft reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| consumeValid | input | 1 | Fetch unit finished one command |
| consumeDwords | input | 8 | Length of that command in dwords |
| ringEmpty | output | 1 | Read pointer equals write pointer |
| fetchReady | output | 1 | Ring enabled and holding commands |
| fetchAddr | output | 48 | Byte address of the next command |
| wbValid | output | 1 | Writeback request valid |
| wbReady | input | 1 | Writeback request accepted |
| wbAddr | output | 48 | Writeback target address |
| wbData | output | 32 | Read-pointer byte offset to store |

## Verification
The bench sweeps ring sizes from 4 to 32 dwords with a varying mix of command lengths and checks each new pointer against arithmetic in the bench. A design that wrapped at the wrong size, or wrapped before masking, returns a pointer beyond the ring. Pulses sent to an empty ring and to a disabled ring must leave the pointer untouched; a design that skipped that gate would run past the producer. The writeback path is driven with a stalled receiver while several commands complete. A design that overwrote the pending data, dropped the merged update, or issued one request per advance shows the wrong `wbData`, or a `wbValid` that stays high.

// File: rtl/ringptr_pkg.sv
package ringptr_pkg;

  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_BASE_LO = 3'd1,
    REG_BASE_HI = 3'd2,
    REG_RPTR    = 3'd3,
    REG_WPTR    = 3'd4,
    REG_WB_LO   = 3'd5,
    REG_WB_HI   = 3'd6
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrBaseLo;
    logic wrBaseHi;
    logic wrRptr;
    logic wrWptr;
    logic wrWbLo;
    logic wrWbHi;
    logic advance;
    logic capture;
  } ringStrobes_t;

endpackage

// File: rtl/ringptr_ctrl.sv
module ringptr_ctrl
  import ringptr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [2:0]   regAddr,
  input  logic         consumeValid,
  input  logic         ringEnable,
  input  logic         ringEmpty,
  input  logic         wbEnable,
  input  logic         wbReady,
  output ringStrobes_t strb,
  output logic         wbValid
);

  logic pending, validNext, pendNext, accept, advance, capture;

  // a software pointer write wins over a consume in the same cycle
  assign advance = consumeValid && ringEnable && !ringEmpty &&
                   !(regWrEn && regAddr == REG_RPTR);
  assign accept  = wbValid && wbReady;

  always_comb begin
    validNext = wbValid;
    pendNext  = pending;
    capture   = 1'b0;
    if (accept) begin
      validNext = 1'b0;
      if (pending) begin
        validNext = 1'b1;
        capture   = 1'b1;
        pendNext  = 1'b0;
      end
    end
    if (advance && wbEnable) begin
      if (!wbValid || accept) begin
        validNext = 1'b1;
        capture   = 1'b1;
        pendNext  = 1'b0;
      end else begin
        pendNext  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      pending <= 1'b0;
    end else begin
      wbValid <= validNext;
      pending <= pendNext;
    end
  end

  always_comb begin
    strb          = '0;
    strb.wrCtrl   = regWrEn && regAddr == REG_CTRL;
    strb.wrBaseLo = regWrEn && regAddr == REG_BASE_LO;
    strb.wrBaseHi = regWrEn && regAddr == REG_BASE_HI;
    strb.wrRptr   = regWrEn && regAddr == REG_RPTR;
    strb.wrWptr   = regWrEn && regAddr == REG_WPTR;
    strb.wrWbLo   = regWrEn && regAddr == REG_WB_LO;
    strb.wrWbHi   = regWrEn && regAddr == REG_WB_HI;
    strb.advance  = advance;
    strb.capture  = capture;
  end

endmodule

// File: rtl/ringptr_datapath.sv
module ringptr_datapath
  import ringptr_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int DATA_W   = 32,
  parameter int PTR_BITS = 16,
  parameter int SIZE_W   = 5,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobes_t      strb,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [CNT_W-1:0]  consumeDwords,
  output logic [DATA_W-1:0] regRdData,
  output logic              ringEnable,
  output logic              wbEnable,
  output logic              ringEmpty,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);

  localparam int CTRL_W   = SIZE_W + 2;
  localparam int BHI_W    = ADDR_W - 40;
  localparam int WHI_W    = ADDR_W - 32;
  localparam int PAD_W    = DATA_W - PTR_BITS - 2;

  logic [CTRL_W-1:0]   ctrlReg;
  logic [31:0]         baseLo;
  logic [BHI_W-1:0]    baseHi;
  logic [PTR_BITS-1:0] rptr, wptr, rptrNext, sizeMask, snap;
  logic [29:0]         wbLo;
  logic [WHI_W-1:0]    wbHi;
  logic [SIZE_W-1:0]   sizeLog2, effSize;
  logic [PTR_BITS:0]   fullMask;

  assign ringEnable = ctrlReg[0];
  assign sizeLog2   = ctrlReg[SIZE_W:1];
  assign wbEnable   = ctrlReg[CTRL_W-1];
  assign effSize    = (sizeLog2 > SIZE_W'(PTR_BITS)) ? SIZE_W'(PTR_BITS) : sizeLog2;
  assign fullMask   = ((PTR_BITS+1)'(1) << effSize) - (PTR_BITS+1)'(1);
  assign sizeMask   = fullMask[PTR_BITS-1:0];
  assign rptrNext   = (rptr + PTR_BITS'(consumeDwords)) & sizeMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      baseLo  <= '0;
      baseHi  <= '0;
      rptr    <= '0;
      wptr    <= '0;
      wbLo    <= '0;
      wbHi    <= '0;
      snap    <= '0;
    end else begin
      if (strb.wrCtrl)   ctrlReg <= regWrData[CTRL_W-1:0];
      if (strb.wrBaseLo) baseLo  <= regWrData[31:0];
      if (strb.wrBaseHi) baseHi  <= regWrData[BHI_W-1:0];
      if (strb.wrWptr)   wptr    <= regWrData[PTR_BITS+1:2];
      if (strb.wrWbLo)   wbLo    <= regWrData[31:2];
      if (strb.wrWbHi)   wbHi    <= regWrData[WHI_W-1:0];
      if (strb.wrRptr)        rptr <= regWrData[PTR_BITS+1:2];
      else if (strb.advance)  rptr <= rptrNext;
      if (strb.capture)  snap <= strb.advance ? rptrNext : rptr;
    end
  end

  assign ringEmpty = (rptr == wptr);
  assign fetchAddr = {baseHi, baseLo, 8'h00} + ADDR_W'({rptr, 2'b00});
  assign wbAddr    = {wbHi, wbLo, 2'b00};
  assign wbData    = {{PAD_W{1'b0}}, snap, 2'b00};

  always_comb begin
    case (regAddr)
      REG_CTRL:    regRdData = DATA_W'(ctrlReg);
      REG_BASE_LO: regRdData = DATA_W'(baseLo);
      REG_BASE_HI: regRdData = DATA_W'(baseHi);
      REG_RPTR:    regRdData = {{PAD_W{1'b0}}, rptr, 2'b00};
      REG_WPTR:    regRdData = {{PAD_W{1'b0}}, wptr, 2'b00};
      REG_WB_LO:   regRdData = DATA_W'({wbLo, 2'b00});
      REG_WB_HI:   regRdData = DATA_W'(wbHi);
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: rtl/ringptr_top.sv
module ringptr_top
  import ringptr_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int DATA_W   = 32,
  parameter int PTR_BITS = 16,
  parameter int SIZE_W   = 5,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              consumeValid,
  input  logic [CNT_W-1:0]  consumeDwords,
  output logic              ringEmpty,
  output logic              fetchReady,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);

  ringStrobes_t strb;
  logic ringEnable, wbEnable;

  ringptr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .consumeValid(consumeValid), .ringEnable(ringEnable), .ringEmpty(ringEmpty),
    .wbEnable(wbEnable), .wbReady(wbReady), .strb(strb), .wbValid(wbValid)
  );

  ringptr_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_BITS(PTR_BITS),
    .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr), .regWrData(regWrData),
    .consumeDwords(consumeDwords), .regRdData(regRdData), .ringEnable(ringEnable),
    .wbEnable(wbEnable), .ringEmpty(ringEmpty), .fetchAddr(fetchAddr),
    .wbAddr(wbAddr), .wbData(wbData)
  );

  assign fetchReady = ringEnable && !ringEmpty;

endmodule

// File: rtl/ringptr_checker.sv
module ringptr_checker #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              consumeValid,
  input logic              ringEmpty,
  input logic              fetchReady,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              wbValid,
  input logic              wbReady,
  input logic [DATA_W-1:0] wbData
);

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rstN) |-> ringEmpty && !fetchReady && !wbValid);

  assert_ignore_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    consumeValid && !fetchReady && !regWrEn |=> $stable(fetchAddr));

  assert_wb_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbValid) |-> $past(consumeValid));

  assert_wb_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbValid && !wbReady |=> wbValid && $stable(wbData));

endmodule

bind ringptr_top ringptr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .consumeValid(consumeValid),
  .ringEmpty(ringEmpty), .fetchReady(fetchReady), .fetchAddr(fetchAddr),
  .wbValid(wbValid), .wbReady(wbReady), .wbData(wbData)
);

// File: tb/ringptr_top_test.sv
module ringptr_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        consumeValid = 1'b0;
  logic [7:0]  consumeDwords = 8'd0;
  logic        ringEmpty, fetchReady, wbValid;
  logic        wbReady = 1'b1;
  logic [47:0] fetchAddr, wbAddr;
  logic [31:0] wbData;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  ringptr_top uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .consumeValid(consumeValid),
    .consumeDwords(consumeDwords), .ringEmpty(ringEmpty), .fetchReady(fetchReady),
    .fetchAddr(fetchAddr), .wbValid(wbValid), .wbReady(wbReady),
    .wbAddr(wbAddr), .wbData(wbData)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic consume(input int n);
    @(negedge clk);
    consumeValid = 1'b1; consumeDwords = 8'(n);
    @(negedge clk);
    consumeValid = 1'b0;
    #1;
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [47:0] base;
    int r;
    base = {8'h12, 32'h00AB_CDEF, 8'h00};

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 regs", 64'(v), 64'd0);
    end
    chk("R1 empty", 64'(ringEmpty), 64'd1);
    chk("R1 fetchReady", 64'(fetchReady), 64'd0);
    chk("R1 wbValid", 64'(wbValid), 64'd0);

    // R2 pointer masking
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v);
    chk("R2 rptr mask", 64'(v), 64'h3fffc);
    wr(3'd4, 32'h1234_5677); rd(3'd4, v);
    chk("R2 wptr mask", 64'(v), 64'(32'h1234_5677 & 32'h3fffc));
    wr(3'd3, 0); wr(3'd4, 0);
    rd(3'd3, v); chk("R2 rptr zero", 64'(v), 64'd0);

    // R3 control fields
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v);
    chk("R3 ctrl readback", 64'(v), 64'h7f);
    wr(3'd0, 32'd0);

    // R4 base address
    wr(3'd1, 32'h00AB_CDEF); wr(3'd2, 32'h12);
    rd(3'd1, v); chk("R4 base lo", 64'(v), 64'h00AB_CDEF);
    rd(3'd2, v); chk("R4 base hi", 64'(v), 64'h12);
    chk("R4 fetchAddr", 64'(fetchAddr), 64'(base));

    // R7 wptr while disabled
    wr(3'd4, 32'h40); #1;
    chk("R7 no fetch while disabled", 64'(fetchReady), 64'd0);
    chk("R5 not empty", 64'(ringEmpty), 64'd0);
    rd(3'd4, v); chk("R7 wptr updated", 64'(v), 64'h40);
    wr(3'd0, 32'h1 | (32'd4 << 1)); #1;
    chk("R7 fetch after enable", 64'(fetchReady), 64'd1);

    // R6 sweep over ring sizes
    for (int sz = 2; sz <= 5; sz++) begin
      wr(3'd0, 32'h1 | (32'(sz) << 1));
      wr(3'd3, 0); wr(3'd4, 32'h3fffc);
      r = 0;
      for (int i = 0; i < 20; i++) begin
        int n;
        n = 1 + (i * 5 + sz) % 7;
        consume(n);
        r = (r + n) % (1 << sz);
        rd(3'd3, v);
        chk("R6 wrap", 64'(v), 64'(r * 4));
        chk("R4 fetchAddr track", 64'(fetchAddr), 64'(base + 48'(r * 4)));
      end
      chk("R8 no wb when disabled", 64'(wbValid), 64'd0);
      // empty ring ignores consume
      wr(3'd4, 32'(r * 4)); #1;
      chk("R5 empty", 64'(ringEmpty), 64'd1);
      chk("R5 no fetch when empty", 64'(fetchReady), 64'd0);
      consume(3);
      rd(3'd3, v); chk("R6 empty ignore", 64'(v), 64'(r * 4));
      // disabled ring ignores consume
      wr(3'd4, 32'h3fffc);
      wr(3'd0, 32'(sz) << 1);
      consume(2);
      rd(3'd3, v); chk("R6 disabled ignore", 64'(v), 64'(r * 4));
    end

    // R8 writeback
    wr(3'd0, 32'h1 | (32'd4 << 1) | 32'h40);
    wr(3'd3, 0); wr(3'd4, 32'h3fffc);
    wr(3'd5, 32'h1000_0007); wr(3'd6, 32'h55);
    wbReady = 1'b1;
    consume(5);
    chk("R8 wbValid", 64'(wbValid), 64'd1);
    chk("R8 wbData", 64'(wbData), 64'd20);
    chk("R8 wbAddr", 64'(wbAddr), 64'h0055_1000_0004);
    @(negedge clk); #1;
    chk("R8 wb accepted", 64'(wbValid), 64'd0);

    // R9 stalled receiver, coalescing
    wbReady = 1'b0;
    consume(2);                 // r = 7
    chk("R9 first req", 64'(wbData), 64'd28);
    consume(3);                 // r = 10
    chk("R9 hold valid", 64'(wbValid), 64'd1);
    chk("R9 hold data", 64'(wbData), 64'd28);
    consume(9);                 // r = 3
    chk("R9 hold data again", 64'(wbData), 64'd28);
    wbReady = 1'b1;
    @(negedge clk); #1;
    chk("R9 follow-up valid", 64'(wbValid), 64'd1);
    chk("R9 follow-up data", 64'(wbData), 64'd12);
    @(negedge clk); #1;
    chk("R9 single follow-up", 64'(wbValid), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule